// File: doc/BRIEF.md
# Pipelined Packet Rule Classifier

This block gives a forward or drop verdict for each packet. An upstream header parser supplies one descriptor per clock. The descriptor carries a valid flag, a fixed tuple of header fields and one valid bit per field. The descriptor passes through a linear chain of rule stages. Each stage holds exactly one rule and is built as four registered substages:

- capture of the descriptor together with a private copy of the stage's rule;
- per-field comparison;
- reduction of the field results to a single hit;
- merging of that hit with the decision carried in from earlier stages.

The first stage in the chain whose rule hits decides the verdict. A descriptor that no rule hits takes a default action from an input pin. The descriptor leaves the chain unchanged, aligned with its verdict, after a fixed latency.

A separate configuration port streams in a whole new rule set, one rule per write. The new set replaces the old one atomically in the cycle its final rule is written. Traffic never pauses and is never diverted. Each stage snapshots its rule at the moment a packet enters that stage, so a switch-over can never mix two rule contents inside one stage's evaluation.

Top module: `rule_chain_classifier`

## Requirements
- R1: While reset is held and after it is released, out_valid is low until a descriptor arrives. The rule set resets to all-empty, so every packet then receives the default action with out_matched low.
- R2: A descriptor is accepted on every cycle in_valid is high, with no stall. It reappears on out_valid/out_fields/out_fvalid exactly 4*NSTAGE cycles later, unchanged and in arrival order, and nothing else appears on the output.
- R3: Field f is taken from in_fields[f*FW +: FW], and its valid bit is in_fvalid[f]. An enabled field matches only when its valid bit is set and (field & mask) equals (value & mask). A field whose enable bit is clear always matches.
- R4: A rule hits only if its active bit is set. With the invert bit clear, it hits when all field matches are true; with the invert bit set, it hits when at least one field match is false.
- R5: The lowest-numbered stage whose rule hits decides the verdict: out_fwd equals that rule's action bit (1 forward, 0 drop) and out_matched is 1. Later stages cannot override it.
- R6: When no stage hits, out_matched is 0 and out_fwd equals dflt_fwd in the output cycle.
- R7: Rule writes (cfg_valid high) fill stages in order 0 to NSTAGE-1. cfg_first forces the write to stage 0 and abandons any partial load. The rules in use do not change until the write to stage NSTAGE-1, and then all stages switch together.
- R8: A packet entering stage k before or on the clock edge that writes the final rule is judged at stage k by the old rule. A packet entering stage k after that edge is judged by the new rule. Later reloads never affect a packet already inside that stage.
- R9: The rule word (cfg_rule) has this layout:

  | Bits | Meaning |
  |---|---|
  | 0 | active |
  | 1 | invert |
  | 2 | action |
  | 3 +: NFIELD | per-field enables |
  | 3+NFIELD+2*FW*f +: FW | value of field f |
  | 3+NFIELD+2*FW*f+FW +: FW | mask of field f |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Descriptor present this cycle |
| in_fields | input | NFIELD*FW | Parsed header fields, field f at f*FW |
| in_fvalid | input | NFIELD | Per-field valid bits from the parser |
| dflt_fwd | input | 1 | Action when no rule hits (1 forward) |
| cfg_valid | input | 1 | Rule write strobe |
| cfg_first | input | 1 | This write targets stage 0 |
| cfg_rule | input | 3+NFIELD+2*NFIELD*FW | Rule word, layout per R9 |
| out_valid | output | 1 | Descriptor leaving the chain |
| out_fields | output | NFIELD*FW | Fields of the leaving descriptor |
| out_fvalid | output | NFIELD | Field valid bits of the leaving descriptor |
| out_matched | output | 1 | Some rule decided the verdict |
| out_fwd | output | 1 | Verdict: 1 forward, 0 drop |

## Verification
The bench builds the chain with NSTAGE=3, NFIELD=4 and FW=16. With a 12-cycle latency, a mid-stream reload lands while packets sit in different stages, so one packet can meet the old rule early in the chain and the new one later. Three stages are also enough to have a first hit shadow a later contradicting rule and an inverted rule sit behind both. The narrow fields keep masked comparisons and hand-picked values readable, while every field position and bit of the rule layout stays exercised.

// File: rtl/rule_chain_classifier.sv
`timescale 1ns/1ps
module rule_chain_classifier #(
  parameter int NSTAGE = 4,
  parameter int NFIELD = 4,
  parameter int FW     = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  input  logic [NFIELD*FW-1:0]           in_fields,
  input  logic [NFIELD-1:0]              in_fvalid,
  input  logic                           dflt_fwd,
  input  logic                           cfg_valid,
  input  logic                           cfg_first,
  input  logic [3+NFIELD+2*NFIELD*FW-1:0] cfg_rule,
  output logic                           out_valid,
  output logic [NFIELD*FW-1:0]           out_fields,
  output logic [NFIELD-1:0]              out_fvalid,
  output logic                           out_matched,
  output logic                           out_fwd
);
  localparam int DW = NFIELD * FW;
  localparam int RW = 3 + NFIELD + 2 * NFIELD * FW;
  localparam int EB = 3;
  localparam int VB = 3 + NFIELD;
  localparam int IW = (NSTAGE > 1) ? $clog2(NSTAGE) : 1;

  logic [RW-1:0] act_rule [NSTAGE];
  logic [RW-1:0] shadow   [NSTAGE];
  logic [IW-1:0] cfg_idx;
  logic [IW-1:0] wr_idx;
  logic          wr_last;

  assign wr_idx  = cfg_first ? '0 : cfg_idx;
  assign wr_last = (wr_idx == IW'(NSTAGE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_idx <= '0;
      for (int j = 0; j < NSTAGE; j++) act_rule[j] <= '0;
    end else if (cfg_valid) begin
      if (wr_last) begin
        cfg_idx <= '0;
        for (int j = 0; j < NSTAGE; j++)
          act_rule[j] <= (j == NSTAGE - 1) ? cfg_rule : shadow[j];
      end else begin
        cfg_idx <= wr_idx + IW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cfg_valid && !wr_last) shadow[wr_idx] <= cfg_rule;
  end

  logic [NSTAGE:0] c_v, c_dec, c_vd;
  logic [DW-1:0]     c_f  [NSTAGE+1];
  logic [NFIELD-1:0] c_fv [NSTAGE+1];

  assign c_v[0]   = in_valid;
  assign c_dec[0] = 1'b0;
  assign c_vd[0]  = 1'b0;
  assign c_f[0]   = in_fields;
  assign c_fv[0]  = in_fvalid;

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    logic              s1_v, s2_v, s3_v, s4_v;
    logic [DW-1:0]     s1_f, s2_f, s3_f, s4_f;
    logic [NFIELD-1:0] s1_fv, s2_fv, s3_fv, s4_fv;
    logic              s1_dec, s2_dec, s3_dec, s4_dec;
    logic              s1_vd, s2_vd, s3_vd, s4_vd;
    logic [RW-1:0]     s1_r;
    logic [NFIELD-1:0] fm_c, s2_fm;
    logic              s2_on, s2_neg, s2_act;
    logic              s3_hit, s3_act;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_v <= 1'b0;
        s2_v <= 1'b0;
        s3_v <= 1'b0;
        s4_v <= 1'b0;
      end else begin
        s1_v <= c_v[k];
        s2_v <= s1_v;
        s3_v <= s2_v;
        s4_v <= s3_v;
      end
    end

    always_comb begin
      for (int f = 0; f < NFIELD; f++) begin
        fm_c[f] = !s1_r[EB+f] ||
                  (s1_fv[f] &&
                   ((s1_f[f*FW +: FW] & s1_r[VB+2*FW*f+FW +: FW]) ==
                    (s1_r[VB+2*FW*f +: FW] & s1_r[VB+2*FW*f+FW +: FW])));
      end
    end

    always_ff @(posedge clk) begin
      s1_f   <= c_f[k];
      s1_fv  <= c_fv[k];
      s1_dec <= c_dec[k];
      s1_vd  <= c_vd[k];
      s1_r   <= act_rule[k];

      s2_f   <= s1_f;
      s2_fv  <= s1_fv;
      s2_dec <= s1_dec;
      s2_vd  <= s1_vd;
      s2_fm  <= fm_c;
      s2_on  <= s1_r[0];
      s2_neg <= s1_r[1];
      s2_act <= s1_r[2];

      s3_f   <= s2_f;
      s3_fv  <= s2_fv;
      s3_dec <= s2_dec;
      s3_vd  <= s2_vd;
      s3_hit <= s2_on & ((&s2_fm) ^ s2_neg);
      s3_act <= s2_act;

      s4_f   <= s3_f;
      s4_fv  <= s3_fv;
      s4_dec <= s3_dec | s3_hit;
      s4_vd  <= s3_dec ? s3_vd : (s3_hit & s3_act);
    end

    assign c_v[k+1]   = s4_v;
    assign c_f[k+1]   = s4_f;
    assign c_fv[k+1]  = s4_fv;
    assign c_dec[k+1] = s4_dec;
    assign c_vd[k+1]  = s4_vd;
  end

  assign out_valid   = c_v[NSTAGE];
  assign out_fields  = c_f[NSTAGE];
  assign out_fvalid  = c_fv[NSTAGE];
  assign out_matched = c_dec[NSTAGE];
  assign out_fwd     = c_dec[NSTAGE] ? c_vd[NSTAGE] : dflt_fwd;
endmodule

// File: rtl/rule_chain_classifier_chk.sv
`timescale 1ns/1ps
module rule_chain_classifier_chk #(
  parameter int NSTAGE = 4,
  parameter int IW     = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          out_valid,
  input logic          out_matched,
  input logic          out_fwd,
  input logic          dflt_fwd,
  input logic [IW-1:0] cfg_idx
);
  localparam int LAT = 4 * NSTAGE;
  localparam int CW  = $clog2(LAT + 2) + 1;

  logic [CW-1:0] inflight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else        inflight <= inflight + CW'(in_valid) - CW'(out_valid);
  end

  // R2: the chain never holds more descriptors than its latency
  a_r2_inflight_bound: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= CW'(LAT));

  // R2: no output without an accepted descriptor
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> inflight != '0);

  // R6: unmatched descriptors carry the default action
  a_r6_default: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_matched) |-> out_fwd == dflt_fwd);

  // R7: load pointer stays inside the rule set
  a_r7_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cfg_idx) < NSTAGE);
endmodule

bind rule_chain_classifier rule_chain_classifier_chk #(.NSTAGE(NSTAGE), .IW(IW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .out_matched(out_matched),
  .out_fwd    (out_fwd),
  .dflt_fwd   (dflt_fwd),
  .cfg_idx    (cfg_idx)
);

// File: tb/test_rule_chain_classifier.sv
`timescale 1ns/1ps
module test_rule_chain_classifier;
  localparam int NS  = 3;
  localparam int NF  = 4;
  localparam int FW  = 16;
  localparam int DW  = NF * FW;
  localparam int RW  = 3 + NF + 2 * NF * FW;
  localparam int VB  = 3 + NF;
  localparam int LAT = 4 * NS;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [DW-1:0] in_fields;
  logic [NF-1:0] in_fvalid;
  logic dflt_fwd;
  logic cfg_valid, cfg_first;
  logic [RW-1:0] cfg_rule;
  logic out_valid;
  logic [DW-1:0] out_fields;
  logic [NF-1:0] out_fvalid;
  logic out_matched, out_fwd;

  always #2 clk = ~clk;

  rule_chain_classifier #(.NSTAGE(NS), .NFIELD(NF), .FW(FW)) i_rule_chain_classifier (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fields(in_fields),
    .in_fvalid(in_fvalid), .dflt_fwd(dflt_fwd), .cfg_valid(cfg_valid),
    .cfg_first(cfg_first), .cfg_rule(cfg_rule), .out_valid(out_valid),
    .out_fields(out_fields), .out_fvalid(out_fvalid),
    .out_matched(out_matched), .out_fwd(out_fwd));

  int checks = 0;
  int fails  = 0;
  int unsigned cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  logic [DW-1:0]   q_f  [$];
  logic [NF-1:0]   q_fv [$];
  int unsigned     q_c  [$];
  string           q_req[$];

  logic [RW-1:0] hist [8][NS];
  int unsigned   hedge [8];
  int            nh;

  logic [RW-1:0] nr [NS];
  logic [FW-1:0] tv [NF];
  logic [FW-1:0] tm [NF];

  function automatic logic [DW-1:0] pk(input logic [FW-1:0] a, b, c, d);
    return {d, c, b, a};
  endfunction

  // R9 layout: active, invert, action, enables, then value/mask per field
  function automatic logic [RW-1:0] mk(input logic on, neg, fwd, input logic [NF-1:0] en);
    logic [RW-1:0] r;
    r = '0;
    r[0] = on;
    r[1] = neg;
    r[2] = fwd;
    r[3 +: NF] = en;
    for (int f = 0; f < NF; f++) begin
      r[VB + 2*FW*f +: FW]      = tv[f];
      r[VB + 2*FW*f + FW +: FW] = tm[f];
    end
    return r;
  endfunction

  task automatic clr();
    for (int f = 0; f < NF; f++) begin
      tv[f] = '0;
      tm[f] = '0;
    end
  endtask

  function automatic void predict(input logic [DW-1:0] f, input logic [NF-1:0] fv,
                                  input int unsigned c, output logic m, output logic w);
    logic [RW-1:0] r;
    logic all_ok, hit;
    logic [FW-1:0] v, mk_, x;
    m = 1'b0;
    w = dflt_fwd;
    for (int k = 0; k < NS; k++) begin
      int unsigned e;
      int s;
      e = c + 1 + 4 * k;
      s = 0;
      for (int h = 0; h < nh; h++) if (hedge[h] < e) s = h;
      r = hist[s][k];
      all_ok = 1'b1;
      for (int fi = 0; fi < NF; fi++) begin
        v   = r[VB + 2*FW*fi +: FW];
        mk_ = r[VB + 2*FW*fi + FW +: FW];
        x   = f[fi*FW +: FW];
        if (r[3+fi] && !(fv[fi] && ((x & mk_) == (v & mk_)))) all_ok = 1'b0;
      end
      hit = r[0] && (all_ok != r[1]);
      if (!m && hit) begin
        m = 1'b1;
        w = r[2];
      end
    end
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [DW-1:0] m_f;
  logic [NF-1:0] m_fv;
  int unsigned   m_c;
  string         m_req;
  logic          e_m, e_w;

  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      checks++;
      if (q_c.size() == 0) begin
        fails++;
        $display("FAIL R2 unexpected output actual=valid expected=idle");
      end else begin
        m_f = q_f.pop_front();
        m_fv = q_fv.pop_front();
        m_c = q_c.pop_front();
        m_req = q_req.pop_front();
        predict(m_f, m_fv, m_c, e_m, e_w);
        if (out_fields !== m_f || out_fvalid !== m_fv || out_matched !== e_m ||
            out_fwd !== e_w || (cyc - m_c) != LAT) begin
          fails++;
          $display("FAIL %s actual=f%h/v%h/m%b/w%b/lat%0d expected=f%h/v%h/m%b/w%b/lat%0d",
                   m_req, out_fields, out_fvalid, out_matched, out_fwd, cyc - m_c,
                   m_f, m_fv, e_m, e_w, LAT);
        end
      end
    end
  end

  task automatic send(input logic [DW-1:0] f, input logic [NF-1:0] fv, input string req);
    @(negedge clk);
    in_valid  = 1'b1;
    in_fields = f;
    in_fvalid = fv;
    q_f.push_back(f);
    q_fv.push_back(fv);
    q_c.push_back(cyc);
    q_req.push_back(req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic load(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cfg_valid = 1'b1;
      cfg_first = (i == 0);
      cfg_rule  = nr[i];
      if (i == NS - 1) begin
        for (int k = 0; k < NS; k++) hist[nh][k] = nr[k];
        hedge[nh] = cyc + 1;
        nh++;
      end
    end
    @(negedge clk);
    cfg_valid = 1'b0;
    cfg_first = 1'b0;
  endtask

  task automatic set_a();
    clr(); tv[0] = 16'h1111; tm[0] = 16'hFFFF;
    nr[0] = mk(1'b1, 1'b0, 1'b0, 4'b0001);
    clr(); tv[1] = 16'h0A00; tm[1] = 16'hFF00; tv[2] = 16'h0002; tm[2] = 16'h000F;
    nr[1] = mk(1'b1, 1'b0, 1'b1, 4'b0110);
    clr(); tv[3] = 16'h0050; tm[3] = 16'hFFFF;
    nr[2] = mk(1'b1, 1'b1, 1'b0, 4'b1000);
  endtask

  task automatic set_b();
    clr(); tv[0] = 16'h2222; tm[0] = 16'hFFFF;
    nr[0] = mk(1'b1, 1'b0, 1'b0, 4'b0001);
    clr();
    nr[1] = mk(1'b1, 1'b0, 1'b1, 4'b0000);
    nr[2] = mk(1'b0, 1'b0, 1'b0, 4'b1111);
  endtask

  task automatic stream(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      send(pk((i % 3 == 0) ? 16'h1111 : 16'(i), 16'h0A00 | 16'(i), 16'(i),
              16'h0050 + 16'(i % 2)),
           (i % 5 == 0) ? 4'b1110 : 4'b1111, req);
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_fields = '0; in_fvalid = '0;
    dflt_fwd = 1'b1; cfg_valid = 1'b0; cfg_first = 1'b0; cfg_rule = '0;
    for (int k = 0; k < NS; k++) hist[0][k] = '0;
    hedge[0] = 0;
    nh = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(64'(out_valid), 64'd0, "R1 out_valid during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(64'(out_valid), 64'd0, "R1 out_valid after reset");

    // R1/R6: empty rule set gives default action
    send(pk(16'h1111, 16'h0A02, 16'h0002, 16'h0051), 4'hF, "R1 empty set");
    send(pk(16'h0000, 16'h0000, 16'h0000, 16'h0000), 4'h0, "R1 empty set");
    idle(LAT + 2);
    dflt_fwd = 1'b0;
    send(pk(16'h1111, 16'h0A02, 16'h0002, 16'h0051), 4'hF, "R6 empty set drop default");
    idle(LAT + 2);
    dflt_fwd = 1'b1;

    set_a();
    load(NS);
    idle(2);
    send(pk(16'h1111, 16'h0A77, 16'h1232, 16'h0051), 4'hF, "R5 first hit drop");
    send(pk(16'h1111, 16'h0BCD, 16'h0000, 16'h0050), 4'b1110, "R3 field invalid");
    send(pk(16'h0000, 16'h0A77, 16'h1232, 16'h0099), 4'hF, "R3/R9 masked hit fwd");
    send(pk(16'h0000, 16'h0A77, 16'h1232, 16'h0099), 4'b1011, "R3 enabled field invalid");
    send(pk(16'h0000, 16'h0000, 16'h0000, 16'h0051), 4'hF, "R4 inverted hit");
    send(pk(16'h0000, 16'h0000, 16'h0000, 16'h0050), 4'hF, "R6 no hit fwd");
    send(pk(16'h0000, 16'h0000, 16'h0000, 16'h0050), 4'b0111, "R4 inverted on invalid");
    idle(LAT + 2);
    dflt_fwd = 1'b0;
    send(pk(16'h0000, 16'h0000, 16'h0000, 16'h0050), 4'hF, "R6 no hit drop");
    idle(LAT + 2);
    dflt_fwd = 1'b1;
    stream(24, "R2 back-to-back");
    idle(LAT + 2);

    set_b();
    load(NS - 1);
    idle(2);
    send(pk(16'h1111, 16'h0000, 16'h0000, 16'h0050), 4'hF, "R7 partial load ignored");
    send(pk(16'h2222, 16'h0000, 16'h0000, 16'h0050), 4'hF, "R7 partial load ignored");
    idle(LAT + 2);
    load(NS);
    idle(2);
    send(pk(16'h1111, 16'h0000, 16'h0000, 16'h0050), 4'hF, "R7 new set active");
    send(pk(16'h2222, 16'h0000, 16'h0000, 16'h0050), 4'hF, "R7 new set first hit");
    idle(LAT + 2);

    set_a();
    fork
      stream(30, "R8 reload mid-stream");
      begin
        repeat (6) @(negedge clk);
        load(NS);
      end
    join
    idle(LAT + 4);

    check(64'(q_c.size()), 64'd0, "R2 all descriptors delivered");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule